// File: doc/BRIEF.md
# Hard-Decision Trellis Metric Update Stage

This block is the metric engine of a hard-decision Viterbi decoder. The code it decodes has rate 1/2, constraint length 3 and generators 7 and 5 (octal), which gives four trellis states. Each accepted 2-bit symbol is scored against the expected output of every trellis branch by Hamming distance. All four add-compare-select updates then run in the same clock. The block keeps one path metric register per state.

For every symbol it produces two results: one decision bit per state, and the index of the state whose metric is now smallest. A traceback unit stores these and walks them back. A decision bit is the most significant bit of the predecessor that won, so the traceback gets the previous state by shifting the current state right and putting that bit in at the top.

A frame-start flag tells the block that the symbol it comes with opens a new frame. Metrics are normalised so that a fixed-width register never wraps on long streams.

Top module: `hdpm_top`

## Requirements
- R1: The branch metric is the Hamming distance (0 to 2) between the received symbol and the branch output. Symbol bit 1 is compared with the generator-7 output (input xor both stored bits). Symbol bit 0 is compared with the generator-5 output (input xor the oldest stored bit).
- R2: The state is {older bit, newer bit}. A new bit enters at the LSB. State s has two predecessors, {0,s[1]} and {1,s[1]}. Its new metric is the smaller of predecessor metric plus branch metric over those two. All states update on the clock edge that accepts a symbol, and the results appear right after that edge.
- R3: The decision bit of state s (bit s of the decision bus) equals the MSB of the chosen predecessor. On equal sums it is 0.
- R4: The best-state output is the index of the smallest updated metric. On equal metrics the lower index wins.
- R5: When a symbol arrives with frame start set, the stored metrics are ignored. In their place, state 0 counts as metric 0 and every other state as 16.
- R6: After reset the metrics are 0 for state 0 and 16 for the other states. Output valid, the decision bus and the best state are all 0.
- R7: When every updated metric is 32 or more, 32 is subtracted from all of them before they are stored.
- R8: No addition in the update wraps past the 6-bit metric range.
- R9: In a cycle with no valid symbol, the metrics, decisions and best state hold and output valid is low.
- R10: For an error-free coded stream that starts with frame start from state 0, the best state follows the encoder state and its metric stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sym_valid | input | 1 | A symbol is presented this cycle |
| frame_start | input | 1 | The presented symbol opens a new frame |
| sym_bits | input | 2 | Hard-decision symbol: bit 1 for generator 7, bit 0 for generator 5 |
| dec_valid | output | 1 | Outputs were updated by the last edge |
| dec_bits | output | 4 | One decision bit per state, bit s for state s |
| best_state | output | 2 | Index of the state with the smallest metric |
| path_metrics | output | 24 | Metric of state s at bits 6s+5 down to 6s |

## Verification
A wrong metric in any state shows at the metric port on the very edge that stores it. Within a few symbols it also changes which predecessor wins in the states fed by that state, so the decision bits and the best state diverge too. A wrong tie rule or a bad normalisation threshold shows only on particular symbol patterns. For that reason the reference model is compared on every clock, over clean codewords, long noisy runs that cross the normalisation point many times, idle gaps and mid-stream frame restarts.

// File: rtl/hdpm_pkg.sv
package hdpm_pkg;
   // parity of the register taps selected by a generator
   // w bit 0 = newest input, bit k-1 = oldest; g MSB taps the newest input
   function automatic int tap_parity(int w, int g, int k);
      int acc;
      acc = 0;
      for (int i = 0; i < k; i++) begin
         if ((((w >> i) & 1) == 1) && (((g >> (k - 1 - i)) & 1) == 1)) acc = acc ^ 1;
      end
      return acc;
   endfunction
endpackage

// File: rtl/hdpm_branch.sv
module hdpm_branch #(
   parameter int K  = 3,
   parameter int G0 = 7,
   parameter int G1 = 5
) (
   input  logic [1:0]                   sym,
   output logic [2*(1<<(K-1))*2-1:0]    bm_flat
);
   localparam int NS = 1 << (K - 1);

   // metric for (next state ns, predecessor MSB x) at bits ((ns*2+x)*2)+:2
   for (genvar ns = 0; ns < NS; ns++) begin : g_state
      for (genvar x = 0; x < 2; x++) begin : g_pred
         localparam int P  = (x << (K - 2)) | (ns >> 1);
         localparam int W  = (P << 1) | (ns & 1);
         localparam int E1 = hdpm_pkg::tap_parity(W, G0, K);
         localparam int E0 = hdpm_pkg::tap_parity(W, G1, K);
         localparam logic E1B = E1[0];
         localparam logic E0B = E0[0];
         assign bm_flat[(ns*2+x)*2 +: 2] = {1'b0, sym[1] ^ E1B} + {1'b0, sym[0] ^ E0B};
      end
   end
endmodule

// File: rtl/hdpm_acs.sv
module hdpm_acs #(
   parameter int MW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [MW-1:0] pm_up,
   input  logic [MW-1:0] pm_lo,
   input  logic [1:0]    bm_up,
   input  logic [1:0]    bm_lo,
   output logic [MW-1:0] pm_new,
   output logic          dec
);
   logic [MW:0] sum_up, sum_lo;

   assign sum_up = {1'b0, pm_up} + (MW+1)'(bm_up);
   assign sum_lo = {1'b0, pm_lo} + (MW+1)'(bm_lo);
   assign dec    = (sum_lo < sum_up);
   assign pm_new = dec ? sum_lo[MW-1:0] : sum_up[MW-1:0];

   // R8: the wide sums must never reach the extra bit
   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !sum_up[MW] && !sum_lo[MW]);
endmodule

// File: rtl/hdpm_winner.sv
module hdpm_winner #(
   parameter int NS = 4,
   parameter int MW = 6,
   parameter int SW = 2
) (
   input  logic [NS*MW-1:0] m_flat,
   output logic [SW-1:0]    idx,
   output logic [MW-1:0]    minv
);
   always_comb begin
      idx  = '0;
      minv = m_flat[MW-1:0];
      for (int i = 1; i < NS; i++) begin
         if (m_flat[i*MW +: MW] < minv) begin
            minv = m_flat[i*MW +: MW];
            idx  = SW'(i);
         end
      end
   end
endmodule

// File: rtl/hdpm_top.sv
module hdpm_top #(
   parameter int K         = 3,
   parameter int G0        = 7,
   parameter int G1        = 5,
   parameter int MW        = 6,
   parameter int INIT_BIG  = 16,
   parameter int NORM_MODE = 0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          sym_valid,
   input  logic                          frame_start,
   input  logic [1:0]                    sym_bits,
   output logic                          dec_valid,
   output logic [(1<<(K-1))-1:0]         dec_bits,
   output logic [K-2:0]                  best_state,
   output logic [(1<<(K-1))*MW-1:0]      path_metrics
);
   localparam int NS = 1 << (K - 1);
   localparam int SW = K - 1;
   localparam logic [MW-1:0] HALF_V = MW'(1 << (MW - 1));
   localparam logic [MW-1:0] INIT_V = MW'(INIT_BIG);

   if (K < 3 || K > 8) begin : g_bad_k
      $error("hdpm_top: K out of range");
   end
   if (MW < 4 || INIT_BIG < 1 || INIT_BIG >= (1 << (MW - 1))) begin : g_bad_mw
      $error("hdpm_top: metric width or initial value unusable");
   end
   if (NORM_MODE < 0 || NORM_MODE > 1) begin : g_bad_norm
      $error("hdpm_top: NORM_MODE must be 0 or 1");
   end

   logic [MW-1:0]       pm_q  [NS];
   logic [MW-1:0]       base  [NS];
   logic [MW-1:0]       raw   [NS];
   logic [NS*MW-1:0]    raw_flat;
   logic [NS-1:0]       dec_c;
   logic [NS-1:0]       dec_q;
   logic [SW-1:0]       best_c, best_q;
   logic [MW-1:0]       min_raw, sub;
   logic                dv_q;
   logic [2*NS*2-1:0]   bm_flat;

   always_comb begin
      for (int i = 0; i < NS; i++) begin
         if (frame_start) base[i] = (i == 0) ? '0 : INIT_V;
         else             base[i] = pm_q[i];
      end
   end

   hdpm_branch #(.K(K), .G0(G0), .G1(G1)) u_bm (
      .sym     (sym_bits),
      .bm_flat (bm_flat)
   );

   for (genvar s = 0; s < NS; s++) begin : g_acs
      localparam int PU = s >> 1;
      localparam int PL = PU + NS / 2;
      hdpm_acs #(.MW(MW)) u_acs (
         .clk    (clk),
         .rst_n  (rst_n),
         .pm_up  (base[PU]),
         .pm_lo  (base[PL]),
         .bm_up  (bm_flat[(s*2+0)*2 +: 2]),
         .bm_lo  (bm_flat[(s*2+1)*2 +: 2]),
         .pm_new (raw[s]),
         .dec    (dec_c[s])
      );
      assign raw_flat[s*MW +: MW]     = raw[s];
      assign path_metrics[s*MW +: MW] = pm_q[s];
   end

   hdpm_winner #(.NS(NS), .MW(MW), .SW(SW)) u_win (
      .m_flat (raw_flat),
      .idx    (best_c),
      .minv   (min_raw)
   );

   if (NORM_MODE == 0) begin : g_norm_fixed
      assign sub = (min_raw >= HALF_V) ? HALF_V : '0;
   end else begin : g_norm_min
      assign sub = (min_raw >= HALF_V) ? min_raw : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NS; i++) pm_q[i] <= (i == 0) ? '0 : INIT_V;
         dec_q  <= '0;
         best_q <= '0;
         dv_q   <= 1'b0;
      end else begin
         dv_q <= sym_valid;
         if (sym_valid) begin
            for (int i = 0; i < NS; i++) pm_q[i] <= raw[i] - sub;
            dec_q  <= dec_c;
            best_q <= best_c;
         end
      end
   end

   assign dec_valid  = dv_q;
   assign dec_bits   = dec_q;
   assign best_state = best_q;

   // R9: idle cycles leave everything in place
   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !sym_valid |=> (!dec_valid && $stable(path_metrics) && $stable(dec_bits)));
   // R5: a frame opener starts state 0 from zero, so it can only hold a branch metric
   assert_sof_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_valid && frame_start) |=> (pm_q[0] <= MW'(2)));
   // R7: after storing, the smallest metric is below half scale
   assert_norm_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> (pm_q[best_q] < HALF_V));
   // R4: the reported state is never beaten by another
   for (genvar s = 0; s < NS; s++) begin : g_best_chk
      assert_best_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
         dec_valid |-> (pm_q[best_q] <= pm_q[s]));
   end
endmodule

// File: tb/sim_hdpm_top.sv
`timescale 1ns/1ps
module sim_hdpm_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sym_valid = 1'b0;
   logic       frame_start = 1'b0;
   logic [1:0] sym_bits = 2'b00;
   logic       dec_valid;
   logic [3:0] dec_bits;
   logic [1:0] best_state;
   logic [23:0] path_metrics;

   int checks = 0;
   int errors = 0;
   int mpm [4];
   int exp_dec = 0, exp_best = 0, exp_dv = 0;
   int enc_st = 0;
   int lfsr = 16'hACE1;

   always #4 clk = ~clk;

   hdpm_top u0 (
      .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .frame_start(frame_start),
      .sym_bits(sym_bits), .dec_valid(dec_valid), .dec_bits(dec_bits),
      .best_state(best_state), .path_metrics(path_metrics)
   );

   function automatic int pm_at(int s);
      return int'(path_metrics[s*6 +: 6]);
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
      end
   endtask

   task automatic compare_all();
      chk(dec_valid == exp_dv[0], "R9 valid", int'(dec_valid), exp_dv);
      chk(int'(dec_bits) == exp_dec, "R3 decisions", int'(dec_bits), exp_dec);
      chk(int'(best_state) == exp_best, "R4 best state", int'(best_state), exp_best);
      for (int s = 0; s < 4; s++)
         chk(pm_at(s) == mpm[s], "R2 R7 R8 metric", pm_at(s), mpm[s]);
   endtask

   // behavioural model of one accepted symbol
   task automatic model(input int sof, input int sym);
      int b [4];
      int n [4];
      int d, mn, bi;
      for (int s = 0; s < 4; s++) b[s] = sof ? ((s == 0) ? 0 : 16) : mpm[s];
      d = 0;
      for (int ns = 0; ns < 4; ns++) begin
         int c [2];
         for (int x = 0; x < 2; x++) begin
            int u, mid, e, h;
            u = ns & 1; mid = ns >> 1;
            e = (((u ^ mid ^ x) & 1) << 1) | ((u ^ x) & 1);
            h = (sym ^ e);
            c[x] = b[x*2 + mid] + (h & 1) + ((h >> 1) & 1);
         end
         if (c[1] < c[0]) begin n[ns] = c[1]; d |= (1 << ns); end
         else n[ns] = c[0];
      end
      mn = n[0]; bi = 0;
      for (int s = 1; s < 4; s++) if (n[s] < mn) begin mn = n[s]; bi = s; end
      for (int s = 0; s < 4; s++) mpm[s] = (mn >= 32) ? n[s] - 32 : n[s];
      exp_dec = d; exp_best = bi;
   endtask

   task automatic step(input int v, input int sof, input int sym);
      @(negedge clk);
      compare_all();
      sym_valid = v[0]; frame_start = sof[0]; sym_bits = sym[1:0];
      exp_dv = v;
      if (v != 0) model(sof, sym);
   endtask

   function automatic int enc(input int u);
      int s0, s1;
      s0 = enc_st & 1; s1 = (enc_st >> 1) & 1;
      return (((u ^ s0 ^ s1) & 1) << 1) | ((u ^ s1) & 1);
   endfunction

   function automatic int next_rand();
      lfsr = ((lfsr >> 1) | ((((lfsr >> 0) ^ (lfsr >> 2) ^ (lfsr >> 3) ^ (lfsr >> 5)) & 1) << 15)) & 16'hFFFF;
      return lfsr;
   endfunction

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      mpm[0] = 0; mpm[1] = 16; mpm[2] = 16; mpm[3] = 16;
      repeat (3) @(negedge clk);
      // R6: reset values
      compare_all();
      @(negedge clk); rst_n = 1'b1;

      // R1 R5: first symbol of a frame, sym 01
      step(1, 1, 1);
      step(0, 0, 0);
      chk(pm_at(0) == 1, "R1 state0 metric", pm_at(0), 1);
      chk(pm_at(1) == 1, "R1 state1 metric", pm_at(1), 1);
      chk(pm_at(2) == 16, "R5 state2 metric", pm_at(2), 16);

      // R10: error-free codeword from state 0
      enc_st = 0;
      for (int i = 0; i < 40; i++) begin
         int u, c;
         u = (next_rand() >> 3) & 1;
         c = enc(u);
         step(1, (i == 0) ? 1 : 0, c);
         enc_st = ((enc_st << 1) | u) & 3;
         if (i > 0) begin
            chk(pm_at(int'(best_state)) == 0, "R10 best metric zero", pm_at(int'(best_state)), 0);
         end
      end
      step(0, 0, 0);
      chk(int'(best_state) == enc_st, "R10 best follows encoder", int'(best_state), enc_st);

      // R9: idle gaps between symbols
      for (int i = 0; i < 10; i++) begin
         step(1, 0, i & 3);
         step(0, 0, 3);
         step(0, 0, 1);
      end

      // R7 R8: long noisy run through many normalisations
      for (int i = 0; i < 1500; i++) begin
         int r;
         r = next_rand();
         step(((r >> 7) & 7) != 0 ? 1 : 0, 0, r & 3);
      end

      // R5: restart mid-stream
      step(1, 1, 2);
      step(1, 0, 3);
      step(0, 0, 0);

      // R2 R3: constant symbol segments give tie patterns
      for (int i = 0; i < 30; i++) step(1, 0, 3);
      for (int i = 0; i < 30; i++) step(1, 0, 0);
      step(0, 0, 0);
      step(0, 0, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule